// File: doc/BRIEF.md
# Converter Power-Mode Sequencer

This block is the host-side master for a dual-channel, 14-bit, serial-output successive-approximation converter. It drives the converter's active-low select line and its serial clock, and it reads the two data lines. The converter has no command register. Its power state is set by how many serial clock falling edges occur before the select line is released in a "dummy" frame. If select stays low past the tenth falling edge, the converter ends up powered and running. If select is raised after the second falling edge and before the tenth, the converter steps one level deeper into power-down: from normal to partial, and from partial to full.

The controller keeps track of the converter's mode. To reach a requested mode it issues the frames needed, one after another. It holds the converter busy for the wake-up time that the previous mode requires, and it leaves a quiet gap between frames. After reset the mode is unknown, so the controller first runs a full-length dummy frame. It then waits the longer full-power-down wake-up time before it reports ready.

A conversion request made in normal mode runs a 16-edge frame and returns one 14-bit result per channel. A conversion request made in either power-down mode is refused and flagged.

Top module: `sar_pwr_seq`

## Requirements
- R1: While reset is applied, `cs_n` and `sclk` are high, `busy` is high and `mode` reads 3 (unknown). After reset the block issues exactly one long frame of 16 `sclk` falling edges, after which `mode` reads 0 (normal).
- R2: After that first frame, `busy` stays high for at least the full-power-down wake time, counted in system clocks from the `cs_n` falling edge of the frame.
- R3: `sclk` runs at the system clock divided by `DIV` and is high whenever `cs_n` is high. No frame has more than 16 `sclk` falling edges. A long frame has exactly 16. A short frame raises `cs_n` after the 4th falling edge, so it falls between the 2nd and 10th edges.
- R4: Mode requests use `req_op` 1 = normal, 2 = partial, 3 = full. `mode` encodes 0 = normal, 1 = partial, 2 = full, 3 = unknown. From normal, a request for partial issues one short frame, and a request for full issues two short frames.
- R5: From partial, a request for full issues one short frame. From full, a request for partial issues a long frame followed by a short frame.
- R6: A request for normal from partial issues one long frame. `busy` drops no earlier than the partial wake time after that frame's `cs_n` fall, and well before the full wake time.
- R7: A request for normal from full issues one long frame. `busy` stays high for at least the full wake time after that frame's `cs_n` fall.
- R8: `req_op` 0 in normal mode runs one long frame. Each data line is sampled on the `sclk` rising edge that follows each falling edge. The first two samples are discarded, and the remaining 14 form the result MSB first. `res_valid` pulses for one cycle with the results on `res_a`/`res_b`.
- R9: `req_op` 0 while `mode` is 1 or 2 starts no frame and pulses `err` for one cycle.
- R10: Between any two frames, `cs_n` stays high for at least the quiet time.
- R11: Requests are taken only while `busy` is low; any other request is dropped. `ready` is high exactly when `busy` is low and `mode` is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_op | input | 2 | 0 convert, 1 normal, 2 partial, 3 full |
| sdata_a | input | 1 | Serial data from channel A |
| sdata_b | input | 1 | Serial data from channel B |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock to converter |
| busy | output | 1 | Sequence, frame or wait in progress |
| ready | output | 1 | Idle in normal mode, conversion allowed |
| err | output | 1 | One-cycle pulse on a refused conversion |
| mode | output | 2 | Tracked converter mode |
| res_a | output | 14 | Channel A result |
| res_b | output | 14 | Channel B result |
| res_valid | output | 1 | One-cycle pulse when results update |

## Verification
A wrong tracked mode shows up within one request. The next mode request then issues the wrong number or length of frames, which the bench counts on `cs_n` and `sclk`. A wrong conversion request is refused or accepted against the R9 rule. A wake counter loaded with the wrong value, or not loaded at all, shows as `busy` falling too early or too late, measured in cycles from the `cs_n` fall. A shift or slot error shows up in the very next result word, or in the edge count of the very next frame.

// File: rtl/sar_pwr_seq.sv
module sar_pwr_seq #(
  parameter int CLK_MHZ      = 100,
  parameter int DIV          = 4,
  parameter int PART_WAKE_NS = 200,
  parameter int FULL_WAKE_US = 6000,
  parameter int QUIET_NS     = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic        sdata_a,
  input  logic        sdata_b,
  output logic        cs_n,
  output logic        sclk,
  output logic        busy,
  output logic        ready,
  output logic        err,
  output logic [1:0]  mode,
  output logic [13:0] res_a,
  output logic [13:0] res_b,
  output logic        res_valid
);
  localparam int PART_CYC    = (CLK_MHZ * PART_WAKE_NS + 999) / 1000;
  localparam int FULL_CYC    = CLK_MHZ * FULL_WAKE_US;
  localparam int QUIET_CYC   = (CLK_MHZ * QUIET_NS + 999) / 1000;
  localparam int LONG_EDGES  = 16;
  localparam int SHORT_EDGES = 4;
  localparam int WW = $clog2(FULL_CYC + 1);
  localparam int QW = $clog2(QUIET_CYC + 2);
  localparam int PW = $clog2(DIV);
  localparam int SW = $clog2(LONG_EDGES + 1);
  localparam logic [WW-1:0] PART_W  = WW'(PART_CYC);
  localparam logic [WW-1:0] FULL_W  = WW'(FULL_CYC);
  localparam logic [QW-1:0] QUIET_W = QW'(QUIET_CYC);

  localparam logic [1:0] M_NORM = 2'd0, M_PART = 2'd1, M_FULL = 2'd2, M_UNK = 2'd3;
  localparam logic [1:0] OP_CONV = 2'd0, OP_NORM = 2'd1, OP_PART = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP} st_t;

  st_t            st;
  logic [1:0]     mode_q, tgt;
  logic           is_long, is_conv;
  logic [PW-1:0]  ph, ph_n;
  logic [SW-1:0]  slot, slot_n, last_slot;
  logic [WW-1:0]  wake;
  logic [QW-1:0]  quiet;
  logic [13:0]    sh_a, sh_b;
  logic           cs_q, sclk_q, err_q, rv_q;

  logic ph_wrap, sclk_d, frame_end, rise_now;
  logic accept, need_step, conv_ok, conv_bad, step_long;
  logic [1:0] req_mode;

  assign last_slot = is_long ? SW'(LONG_EDGES) : SW'(SHORT_EDGES);
  assign ph_wrap   = (ph == PW'(DIV - 1));
  assign ph_n      = ph_wrap ? '0 : ph + 1'b1;
  assign slot_n    = ph_wrap ? slot + 1'b1 : slot;
  assign sclk_d    = !((slot_n != '0) && (ph_n < PW'(DIV / 2)));
  assign frame_end = (st == S_FRAME) && ph_wrap && (slot == last_slot);
  assign rise_now  = (st == S_FRAME) && (slot != '0) && (ph == PW'(DIV / 2 - 1));

  assign need_step = (st == S_IDLE) && (mode_q != tgt);
  assign accept    = (st == S_IDLE) && (mode_q == tgt) && req_valid;
  assign conv_ok   = accept && (req_op == OP_CONV) && (mode_q == M_NORM);
  assign conv_bad  = accept && (req_op == OP_CONV) && (mode_q != M_NORM);
  assign step_long = (tgt == M_NORM) || (mode_q == M_FULL) || (mode_q == M_UNK);
  assign req_mode  = (req_op == OP_NORM) ? M_NORM : (req_op == OP_PART) ? M_PART : M_FULL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_GAP;
      mode_q  <= M_UNK;
      tgt     <= M_NORM;
      is_long <= 1'b0;
      is_conv <= 1'b0;
      ph      <= '0;
      slot    <= '0;
      wake    <= '0;
      quiet   <= '0;
      sh_a    <= '0;
      sh_b    <= '0;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b1;
      err_q   <= 1'b0;
      rv_q    <= 1'b0;
      res_a   <= '0;
      res_b   <= '0;
    end else begin
      err_q <= conv_bad;
      rv_q  <= 1'b0;
      if (wake != '0) wake <= wake - 1'b1;
      case (st)
        S_IDLE: begin
          if (need_step || conv_ok) begin
            st      <= S_FRAME;
            cs_q    <= 1'b0;
            sclk_q  <= 1'b1;
            ph      <= '0;
            slot    <= '0;
            is_conv <= conv_ok;
            is_long <= conv_ok || step_long;
            if (need_step && step_long)
              wake <= (mode_q == M_PART) ? PART_W : FULL_W;
          end else if (accept && req_op != OP_CONV) begin
            tgt <= req_mode;
          end
        end
        S_FRAME: begin
          ph     <= ph_n;
          slot   <= slot_n;
          sclk_q <= sclk_d;
          if (rise_now) begin
            sh_a <= {sh_a[12:0], sdata_a};
            sh_b <= {sh_b[12:0], sdata_b};
          end
          if (frame_end) begin
            st     <= S_GAP;
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
            quiet  <= QUIET_W;
            if (is_conv) begin
              res_a <= sh_a;
              res_b <= sh_b;
              rv_q  <= 1'b1;
            end else if (is_long) begin
              mode_q <= M_NORM;
            end else begin
              mode_q <= (mode_q == M_NORM) ? M_PART : M_FULL;
            end
          end
        end
        default: begin
          if (quiet != '0) quiet <= quiet - 1'b1;
          else if (wake == '0) st <= S_IDLE;
        end
      endcase
    end
  end

  assign cs_n      = cs_q;
  assign sclk      = sclk_q;
  assign err       = err_q;
  assign res_valid = rv_q;
  assign mode      = mode_q;
  assign busy      = (st != S_IDLE) || (mode_q != tgt);
  assign ready     = !busy && (mode_q == M_NORM);
endmodule

// File: rtl/sar_pwr_seq_chk.sv
module sar_pwr_seq_chk #(
  parameter int QUIET_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_op,
  input logic [1:0] mode,
  input logic       cs_n,
  input logic       sclk,
  input logic       busy,
  input logic       err,
  input logic       res_valid
);
  logic        sclk_p;
  logic [4:0]  ecnt;
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= 1'b1;
      ecnt   <= '0;
      hi_cnt <= 16'(QUIET_CYC);
    end else begin
      sclk_p <= sclk;
      if (cs_n) ecnt <= '0;
      else if (sclk_p && !sclk) ecnt <= ecnt + 1'b1;
      if (!cs_n) hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  assert_edge_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt <= 5'd16);

  assert_quiet_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_cnt >= 16'(QUIET_CYC));

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req_valid && req_op == 2'd0 && mode != 2'd0));

  assert_result_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> mode == 2'd0);

  assert_idle_deselect_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
endmodule

bind sar_pwr_seq sar_pwr_seq_chk #(.QUIET_CYC(QUIET_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .mode(mode), .cs_n(cs_n), .sclk(sclk), .busy(busy), .err(err),
  .res_valid(res_valid)
);

// File: tb/sar_pwr_seq_tb_top.sv
module sar_pwr_seq_tb_top;
  localparam int PART_C  = 100;
  localparam int FULL_C  = 2000;
  localparam int QUIET_C = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic sda = 1'b0, sdb = 1'b0;
  logic cs_n, sclk, busy, ready, err, res_valid;
  logic [1:0] mode;
  logic [13:0] res_a, res_b;

  sar_pwr_seq #(.CLK_MHZ(100), .DIV(4), .PART_WAKE_NS(1000), .FULL_WAKE_US(20), .QUIET_NS(50)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .sdata_a(sda), .sdata_b(sdb), .cs_n(cs_n), .sclk(sclk), .busy(busy),
    .ready(ready), .err(err), .mode(mode), .res_a(res_a), .res_b(res_b),
    .res_valid(res_valid));

  int cyc = 0, nchk = 0, nfail = 0;
  int frames = 0, edges = 0, last_edges = 0, t_fall = 0, t_rise = 0;
  int err_cnt = 0, rv_cnt = 0;
  logic [15:0] wa = '0, wb = '0;
  logic [13:0] got_a = '0, got_b = '0;

  always @(posedge clk) begin
    cyc++;
    if (err === 1'b1) err_cnt++;
    if (res_valid === 1'b1) begin rv_cnt++; got_a = res_a; got_b = res_b; end
  end
  always @(negedge cs_n) begin edges = 0; frames++; t_fall = cyc; end
  always @(posedge cs_n) begin last_edges = edges; t_rise = cyc; end
  always @(negedge sclk) if (cs_n === 1'b0) begin
    edges++;
    if (edges <= 16) begin sda = wa[16 - edges]; sdb = wb[16 - edges]; end
  end

  task automatic chk(input string tag, input int act, input int exp, input bit ok);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic send(input logic [1:0] op);
    @(negedge clk); req_valid = 1'b1; req_op = op;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic wait_idle(output int td);
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    td = cyc;
    if (busy) chk("R11 watchdog busy", 1, 0, 1'b0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset cs_n", int'(cs_n), 1, cs_n === 1'b1);
    chk("R1 reset sclk", int'(sclk), 1, sclk === 1'b1);
    chk("R1 reset busy", int'(busy), 1, busy === 1'b1);
    chk("R1 reset mode", int'(mode), 3, mode === 2'd3);
    rst_n = 1'b1;
  endtask

  task automatic t_power_on;
    int td;
    @(negedge clk);
    wait_idle(td);
    chk("R1 power-on frames", frames, 1, frames == 1);
    chk("R1 power-on edges", last_edges, 16, last_edges == 16);
    chk("R1 power-on mode", int'(mode), 0, mode === 2'd0);
    chk("R11 ready in normal", int'(ready), 1, ready === 1'b1);
    chk("R2 power-on wait", td - t_fall, FULL_C, td - t_fall >= FULL_C);
  endtask

  task automatic t_convert(input logic [15:0] a, input logic [15:0] b);
    int td, r0, f0;
    wa = a; wb = b; r0 = rv_cnt; f0 = frames;
    send(2'd0);
    wait_idle(td);
    chk("R8 one result pulse", rv_cnt - r0, 1, rv_cnt == r0 + 1);
    chk("R8 channel A", int'(got_a), int'(a[13:0]), got_a == a[13:0]);
    chk("R8 channel B", int'(got_b), int'(b[13:0]), got_b == b[13:0]);
    chk("R3 conversion edges", last_edges, 16, last_edges == 16 && frames == f0 + 1);
  endtask

  task automatic t_quiet;
    int td, r1, r0;
    wa = 16'h0155; wb = 16'h3AAA; r0 = rv_cnt;
    send(2'd0); wait_idle(td);
    r1 = t_rise;
    send(2'd0); wait_idle(td);
    chk("R10 quiet gap", t_fall - r1, QUIET_C, t_fall - r1 >= QUIET_C);
    chk("R8 back-to-back results", rv_cnt - r0, 2, rv_cnt == r0 + 2);
  endtask

  task automatic t_mode(input string tag, input logic [1:0] op, input int nfr,
                        input int edg, input logic [1:0] exp_mode);
    int td, f0;
    f0 = frames;
    send(op);
    wait_idle(td);
    chk({tag, " frame count"}, frames - f0, nfr, frames == f0 + nfr);
    chk({tag, " last frame edges"}, last_edges, edg, last_edges == edg);
    chk({tag, " mode"}, int'(mode), int'(exp_mode), mode === exp_mode);
    chk("R11 ready follows mode", int'(ready), int'(exp_mode == 2'd0),
        ready === (exp_mode == 2'd0));
  endtask

  task automatic t_reject;
    int f0, e0, r0;
    f0 = frames; e0 = err_cnt; r0 = rv_cnt;
    send(2'd0);
    repeat (6) @(negedge clk);
    chk("R9 err pulse", err_cnt - e0, 1, err_cnt == e0 + 1);
    chk("R9 no frame", frames - f0, 0, frames == f0 && rv_cnt == r0);
    chk("R9 mode kept", int'(mode), 1, mode === 2'd1 && busy === 1'b0);
  endtask

  task automatic t_wake_partial;
    int td, f0;
    f0 = frames;
    send(2'd1);
    wait_idle(td);
    chk("R6 one long frame", last_edges, 16, last_edges == 16 && frames == f0 + 1);
    chk("R6 wait min", td - t_fall, PART_C, td - t_fall >= PART_C);
    chk("R6 wait short", td - t_fall, PART_C, td - t_fall < FULL_C);
    chk("R6 mode", int'(mode), 0, mode === 2'd0);
  endtask

  task automatic t_wake_full_ignore;
    int td, f0, r0;
    f0 = frames; r0 = rv_cnt;
    send(2'd1);
    repeat (30) @(negedge clk);
    send(2'd0);
    send(2'd2);
    wait_idle(td);
    chk("R7 one long frame", last_edges, 16, last_edges == 16 && frames == f0 + 1);
    chk("R7 full wait", td - t_fall, FULL_C, td - t_fall >= FULL_C);
    chk("R11 busy requests dropped", rv_cnt - r0, 0, rv_cnt == r0);
    chk("R11 mode after drop", int'(mode), 0, mode === 2'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("R11 global watchdog", 0, 1, 1'b0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    t_reset;
    t_power_on;
    t_convert(16'hC000 | 16'h2A5C, 16'h1234);
    t_convert(16'h3FFF, 16'h8000);
    t_quiet;
    t_mode("R4 normal to partial", 2'd2, 1, 4, 2'd1);
    t_reject;
    t_wake_partial;
    t_mode("R4 normal to full", 2'd3, 2, 4, 2'd2);
    t_reject_full;
    t_wake_full_ignore;
    t_mode("R4 to partial again", 2'd2, 1, 4, 2'd1);
    t_mode("R5 partial to full", 2'd3, 1, 4, 2'd2);
    t_mode("R5 full to partial", 2'd2, 2, 4, 2'd1);
    t_wake_partial;
    t_convert(16'h0001, 16'h2000);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  task automatic t_reject_full;
    int f0, e0;
    f0 = frames; e0 = err_cnt;
    send(2'd0);
    repeat (6) @(negedge clk);
    chk("R9 err in full", err_cnt - e0, 1, err_cnt == e0 + 1 && frames == f0);
  endtask
endmodule